// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 32-bit configuration dwords of a type-0 endpoint header. The identity words, the header's writable fields, six base-address slots and an expansion-ROM slot sit in an array of dwords, and each dword carries its own writable-bit mask. The identity values and the layout of every address slot (region kind, log2 of size, prefetchable flag) are fixed by parameters, so the array is built at elaboration. Bits outside a dword's mask keep their reset value for ever.

A requester writes a byte, a 16-bit word or a full dword. It gives the dword index, the byte offset and the size, with the data right-aligned on `wr_data`. The block shifts the data into the right lanes and merges it through the mask. It also handles size probing. When all ones is written as a full dword to a base-address slot, the slot's mask is cut down to the encoded region size, NOT(size-1), so the next read returns the size pattern. The ROM slot does the same when bits 31:11 of a full-dword write are all ones. Reads return the addressed dword, or all ones for an index beyond the array. They are either combinational or registered, as a parameter selects.

The read response is a valid-only stream. The block never stalls and cannot be back-pressured, so the requester must take `rd_data` in the cycle `rd_valid` is high. A write takes effect at the clock edge that samples `wr_en`. A read in that same cycle returns the value from before the write.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, dword 0 reads {DEVICE_ID, VENDOR_ID}, dword 2 reads {CLASS, SUBCLASS, PROG_IF, REVISION}, dword 11 reads {SUBSYS_ID, SUBSYS_VENDOR} and dword 15 reads {16'h0, INT_PIN, 8'h00}, with INT_PIN 1-based.
- R2: Only these bits are writable: bits 15:0 of dword 1, bits 7:0 of dword 3 and bits 7:0 of dword 15. Dwords 0, 2 and 11 and the upper bits of dword 1 never change.
- R3: A write stores (old AND NOT m) OR (shifted data AND m). For a byte write (wr_size=0) the data is bits 7:0 shifted left by 8*wr_off and m is that byte lane ANDed with the writable mask. For a 16-bit write (wr_size=1) the data is bits 15:0 and m is the 16-bit lane ANDed with the mask.
- R4: A 16-bit write with wr_off of 1 or 3 is dropped. A full-dword write (wr_size=2) with a nonzero wr_off is dropped. Size code 3 is dropped.
- R5: A base-address slot resets to 0 with type bits set. A 32-bit memory slot has mask 0xFFFFFFF0 and resets to {PREF,3'b000} in bits 3:0. A 64-bit memory slot resets to {PREF,3'b100}. An I/O slot has mask 0xFFFFFFFC and reads 1 in bit 0. Slots occupy dwords 4 to 9.
- R6: A full-dword write of 0xFFFFFFFF to a base-address slot stores mask AND NOT(2^log2-1), so the next read returns that pattern with the type bits. Four byte writes of 0xFF do not probe.
- R7: The dword after a 64-bit memory slot is fully writable. Probing it returns the upper 32 bits of NOT(2^log2-1).
- R8: Dword 12 (ROM slot) has mask 0xFFFFF800. When bits 31:11 of a full-dword write are all ones, the mask is cut to NOT(2^ROM_LOG2-1).
- R9: A read of an index at or above DEPTH returns 0xFFFFFFFF. A write to such an index changes no dword.
- R10: With READ_REG=1, rd_valid and rd_data follow rd_en one clock later. With READ_REG=0 they follow in the same cycle.
- R11: Unused slots and unlisted dwords read 0 and ignore writes. Reset returns every dword to its initial value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Dword index of the write |
| wr_off | input | 2 | Byte offset in the dword |
| wr_size | input | 2 | 0 byte, 1 word, 2 dword, 3 none |
| wr_data | input | 32 | Right-aligned write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Dword index of the read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The assertions check, on every cycle, the read timing against `rd_en` and the all-ones reply for out-of-range reads. They also check that the identity dwords and the read-only half of dword 1 never move, and that misaligned 16-bit writes leave the target dword untouched. Only the bench's scenarios can show the actual size patterns from probing: the split low and high encodings of a 64-bit slot, the ROM trigger on bits 31:11, and the byte-lane merging. The same goes for a probe being told apart from four separate byte writes of 0xFF.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [1:0] {
    PROBE_NONE = 2'd0,
    PROBE_BAR  = 2'd1,
    PROBE_ROM  = 2'd2
  } probe_e;

  typedef struct packed {
    logic [31:0] init;
    logic [31:0] wmask;
    logic [31:0] probe;
    probe_e      kind;
  } dw_attr_t;

  // region kind codes for a base-address slot
  localparam logic [1:0] RK_NONE  = 2'd0;
  localparam logic [1:0] RK_MEM32 = 2'd1;
  localparam logic [1:0] RK_MEM64 = 2'd2;
  localparam logic [1:0] RK_IO    = 2'd3;

  function automatic logic [31:0] size_lo(input int lg);
    if (lg >= 32) return 32'h0;
    return ~((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [31:0] size_hi(input int lg);
    if (lg <= 32) return 32'hFFFF_FFFF;
    return ~((32'd1 << (lg - 32)) - 32'd1);
  endfunction

  function automatic bit follows_mem64(input logic [11:0] kinds, input int b);
    if (b == 0) return 1'b0;
    return kinds[2*(b-1) +: 2] == RK_MEM64;
  endfunction

  function automatic int prev_log2(input logic [35:0] lgs, input int b);
    if (b == 0) return 0;
    return int'(lgs[6*(b-1) +: 6]);
  endfunction

endpackage

// File: rtl/cfgs_layout.sv
module cfgs_layout
  import cfgs_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter logic [15:0] VENDOR_ID   = 16'h1AB3,
  parameter logic [15:0] DEVICE_ID   = 16'h7E21,
  parameter logic [7:0]  REVISION    = 8'h01,
  parameter logic [7:0]  CLASS       = 8'h04,
  parameter logic [7:0]  SUBCLASS    = 8'h01,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [15:0] SUBSYS_ID   = 16'h0000,
  parameter logic [15:0] SUBSYS_VEN  = 16'h0000,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [11:0] BAR_KIND    = 12'h001,
  parameter logic [5:0]  BAR_PREF    = 6'b0,
  parameter logic [35:0] BAR_LOG2    = {30'd0, 6'd12},
  parameter int          ROM_LOG2    = 0
) (
  output dw_attr_t attr [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_dw
    if (i == 0) begin : g_id
      assign attr[i] = '{init: {DEVICE_ID, VENDOR_ID}, wmask: 32'h0, probe: '1, kind: PROBE_NONE};
    end else if (i == 1) begin : g_cmd
      assign attr[i] = '{init: 32'h0, wmask: 32'h0000_FFFF, probe: '1, kind: PROBE_NONE};
    end else if (i == 2) begin : g_cls
      assign attr[i] = '{init: {CLASS, SUBCLASS, PROG_IF, REVISION}, wmask: 32'h0, probe: '1,
                         kind: PROBE_NONE};
    end else if (i == 3) begin : g_cls_line
      assign attr[i] = '{init: 32'h0, wmask: 32'h0000_00FF, probe: '1, kind: PROBE_NONE};
    end else if (i >= 4 && i <= 9) begin : g_bar
      localparam int         B   = i - 4;
      localparam logic [1:0] K   = BAR_KIND[2*B +: 2];
      localparam int         LG  = int'(BAR_LOG2[6*B +: 6]);
      localparam bit         UP  = follows_mem64(BAR_KIND, B);
      localparam int         PLG = prev_log2(BAR_LOG2, B);
      localparam logic       PF  = BAR_PREF[B];
      if (UP) begin : g_upper
        assign attr[i] = '{init: 32'h0, wmask: 32'hFFFF_FFFF, probe: size_hi(PLG), kind: PROBE_BAR};
      end else if (K == RK_MEM32) begin : g_m32
        assign attr[i] = '{init: {28'h0, PF, 3'b000}, wmask: 32'hFFFF_FFF0, probe: size_lo(LG),
                           kind: PROBE_BAR};
      end else if (K == RK_MEM64) begin : g_m64
        assign attr[i] = '{init: {28'h0, PF, 3'b100}, wmask: 32'hFFFF_FFF0, probe: size_lo(LG),
                           kind: PROBE_BAR};
      end else if (K == RK_IO) begin : g_io
        assign attr[i] = '{init: 32'h1, wmask: 32'hFFFF_FFFC, probe: size_lo(LG), kind: PROBE_BAR};
      end else begin : g_off
        assign attr[i] = '{init: 32'h0, wmask: 32'h0, probe: '1, kind: PROBE_NONE};
      end
    end else if (i == 11) begin : g_ssid
      assign attr[i] = '{init: {SUBSYS_ID, SUBSYS_VEN}, wmask: 32'h0, probe: '1, kind: PROBE_NONE};
    end else if (i == 12 && ROM_LOG2 != 0) begin : g_rom
      assign attr[i] = '{init: 32'h0, wmask: 32'hFFFF_F800, probe: size_lo(ROM_LOG2),
                         kind: PROBE_ROM};
    end else if (i == 15) begin : g_irq
      assign attr[i] = '{init: {16'h0, INT_PIN, 8'h00}, wmask: 32'h0000_00FF, probe: '1,
                         kind: PROBE_NONE};
    end else begin : g_zero
      assign attr[i] = '{init: 32'h0, wmask: 32'h0, probe: '1, kind: PROBE_NONE};
    end
  end

endmodule

// File: rtl/cfgs_merge.sv
module cfgs_merge
  import cfgs_pkg::*;
(
  input  logic [31:0] old_val,
  input  dw_attr_t    attr,
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  input  logic [31:0] data,
  output logic        accept,
  output logic [31:0] new_val
);

  logic [4:0]  sh;
  logic [31:0] lanes;
  logic [31:0] eff;
  logic [31:0] clr;
  logic [31:0] shifted;

  assign sh = {off, 3'b000};

  always_comb begin
    accept  = 1'b0;
    lanes   = 32'h0;
    shifted = 32'h0;
    unique case (size)
      2'd0: begin
        accept  = 1'b1;
        lanes   = 32'h0000_00FF << sh;
        shifted = {24'h0, data[7:0]} << sh;
      end
      2'd1: begin
        accept  = ~off[0];
        lanes   = 32'h0000_FFFF << sh;
        shifted = {16'h0, data[15:0]} << sh;
      end
      2'd2: begin
        accept  = (off == 2'd0);
        lanes   = 32'hFFFF_FFFF;
        shifted = data;
      end
      default: ;
    endcase

    eff = lanes & attr.wmask;
    clr = eff;
    if (size == 2'd2) begin
      clr = attr.wmask;
      if ((attr.kind == PROBE_BAR && &data) || (attr.kind == PROBE_ROM && &data[31:11]))
        eff = eff & attr.probe;
    end
    new_val = (old_val & ~clr) | (shifted & eff);
  end

endmodule

// File: rtl/cfgs_rdport.sv
module cfgs_rdport #(
  parameter int DEPTH    = 64,
  parameter int IDX_W    = 8,
  parameter bit READ_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [31:0]      regs [DEPTH],
  output logic             rd_valid,
  output logic [31:0]      rd_data
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(DEPTH);

  logic [31:0] lookup;
  assign lookup = ({1'b0, rd_idx} < LIM) ? regs[rd_idx[AW-1:0]] : 32'hFFFF_FFFF;

  if (READ_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_valid <= 1'b0;
        rd_data  <= 32'h0;
      end else begin
        rd_valid <= rd_en;
        if (rd_en) rd_data <= lookup;
      end
    end
  end else begin : g_comb
    assign rd_valid = rd_en;
    assign rd_data  = lookup;
  end

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfgs_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          IDX_W       = 8,
  parameter bit          READ_REG    = 1'b1,
  parameter logic [15:0] VENDOR_ID   = 16'h1AB3,
  parameter logic [15:0] DEVICE_ID   = 16'h7E21,
  parameter logic [7:0]  REVISION    = 8'h01,
  parameter logic [7:0]  CLASS       = 8'h04,
  parameter logic [7:0]  SUBCLASS    = 8'h01,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [15:0] SUBSYS_ID   = 16'h0000,
  parameter logic [15:0] SUBSYS_VEN  = 16'h0000,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [11:0] BAR_KIND    = 12'h001,
  parameter logic [5:0]  BAR_PREF    = 6'b0,
  parameter logic [35:0] BAR_LOG2    = {30'd0, 6'd12},
  parameter int          ROM_LOG2    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_off,
  input  logic [1:0]       wr_size,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(DEPTH);

  dw_attr_t    attr [DEPTH];
  logic [31:0] regs [DEPTH];
  logic [AW-1:0] wsel;
  logic        in_range;
  logic        accept;
  logic [31:0] merged;

  cfgs_layout #(
    .DEPTH(DEPTH), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS(CLASS), .SUBCLASS(SUBCLASS), .PROG_IF(PROG_IF), .SUBSYS_ID(SUBSYS_ID),
    .SUBSYS_VEN(SUBSYS_VEN), .INT_PIN(INT_PIN), .BAR_KIND(BAR_KIND), .BAR_PREF(BAR_PREF),
    .BAR_LOG2(BAR_LOG2), .ROM_LOG2(ROM_LOG2)
  ) u_layout (
    .attr(attr)
  );

  assign wsel     = wr_idx[AW-1:0];
  assign in_range = ({1'b0, wr_idx} < LIM);

  cfgs_merge u_merge (
    .old_val(regs[wsel]),
    .attr   (attr[wsel]),
    .off    (wr_off),
    .size   (wr_size),
    .data   (wr_data),
    .accept (accept),
    .new_val(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) regs[k] <= attr[k].init;
    end else if (wr_en && in_range && accept) begin
      regs[wsel] <= merged;
    end
  end

  cfgs_rdport #(.DEPTH(DEPTH), .IDX_W(IDX_W), .READ_REG(READ_REG)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .regs    (regs),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
  parameter int DEPTH    = 64,
  parameter int IDX_W    = 8,
  parameter bit READ_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_off,
  input logic [1:0]       wr_size,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_valid,
  input logic [31:0]      rd_data,
  input logic [31:0]      regs [DEPTH]
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(DEPTH);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_seen;
  always_ff @(posedge clk) if (rd_en) idx_q <= rd_idx;
  assign idx_seen = READ_REG ? idx_q : rd_idx;

  if (READ_REG) begin : g_lat
    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
  end else begin : g_lat0
    p_rd_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == rd_en);
  end

  p_oor_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && ({1'b0, idx_seen} >= LIM)) |-> rd_data == 32'hFFFF_FFFF);

  p_bad_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd1 && wr_off[0] && ({1'b0, wr_idx} < LIM))
    |=> regs[$past(wr_idx[AW-1:0])] == $past(regs[wr_idx[AW-1:0]]));

  p_ident_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[0]) && $stable(regs[2]) && $stable(regs[11]) && $stable(regs[1][31:16]));

endmodule

bind cfg_space_regs cfgs_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .READ_REG(READ_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
  .wr_size(wr_size), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
  .rd_data(rd_data), .regs(regs)
);

// File: tb/sim_cfg_space_regs.sv
`timescale 1ns/1ps
module sim_cfg_space_regs;

  localparam logic [11:0] KINDS = {2'd1, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1};
  localparam logic [5:0]  PREFS = 6'b100100;
  localparam logic [35:0] LOGS  = {6'd20, 6'd0, 6'd0, 6'd33, 6'd8, 6'd12};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_idx = '0;
  logic [1:0] wr_off = '0;
  logic [1:0] wr_size = 2'd3;
  logic [31:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_idx = '0;
  logic rd_valid, rd_valid1;
  logic [31:0] rd_data, rd_data1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_space_regs #(
    .DEPTH(64), .IDX_W(8), .READ_REG(1'b1), .VENDOR_ID(16'h1AB3), .DEVICE_ID(16'h7E21),
    .REVISION(8'h05), .CLASS(8'h04), .SUBCLASS(8'h01), .PROG_IF(8'h00),
    .SUBSYS_ID(16'h2468), .SUBSYS_VEN(16'hABCD), .INT_PIN(8'h01),
    .BAR_KIND(KINDS), .BAR_PREF(PREFS), .BAR_LOG2(LOGS), .ROM_LOG2(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
    .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  cfg_space_regs #(
    .DEPTH(64), .IDX_W(8), .READ_REG(1'b0), .VENDOR_ID(16'h1AB3), .DEVICE_ID(16'h7E21),
    .REVISION(8'h05), .CLASS(8'h04), .SUBCLASS(8'h01), .PROG_IF(8'h00),
    .SUBSYS_ID(16'h2468), .SUBSYS_VEN(16'hABCD), .INT_PIN(8'h01),
    .BAR_KIND(KINDS), .BAR_PREF(PREFS), .BAR_LOG2(LOGS), .ROM_LOG2(16)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
    .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid1), .rd_data(rd_data1)
  );

  // one step: optional write, then read of ridx compared with exp
  typedef struct packed {
    logic        wr;
    logic [7:0]  widx;
    logic [1:0]  off;
    logic [1:0]  size;
    logic [31:0] data;
    logic [7:0]  ridx;
    logic [31:0] exp;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 36;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd0,   32'h7E21_1AB3, 4'd1},  // R1
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd2,   32'h0401_0005, 4'd1},  // R1
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd11,  32'h2468_ABCD, 4'd1},  // R1
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd15,  32'h0000_0100, 4'd1},  // R1
    '{1'b1, 8'd1,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd1,   32'h0000_FFFF, 4'd2},  // R2
    '{1'b1, 8'd0,  2'd0, 2'd2, 32'h0,         8'd0,   32'h7E21_1AB3, 4'd2},  // R2
    '{1'b1, 8'd3,  2'd0, 2'd0, 32'h40,        8'd3,   32'h0000_0040, 4'd3},  // R3
    '{1'b1, 8'd3,  2'd1, 2'd0, 32'h55,        8'd3,   32'h0000_0040, 4'd2},  // R2
    '{1'b1, 8'd15, 2'd0, 2'd2, 32'hFFFF_FFFF, 8'd15,  32'h0000_01FF, 4'd2},  // R2
    '{1'b1, 8'd1,  2'd0, 2'd1, 32'hBEEF,      8'd1,   32'h0000_BEEF, 4'd3},  // R3
    '{1'b1, 8'd1,  2'd1, 2'd1, 32'h1111,      8'd1,   32'h0000_BEEF, 4'd4},  // R4
    '{1'b1, 8'd1,  2'd1, 2'd0, 32'h12,        8'd1,   32'h0000_12EF, 4'd3},  // R3
    '{1'b1, 8'd1,  2'd0, 2'd3, 32'h0,         8'd1,   32'h0000_12EF, 4'd4},  // R4
    '{1'b1, 8'd1,  2'd1, 2'd2, 32'hFFFF_FFFF, 8'd1,   32'h0000_12EF, 4'd4},  // R4
    '{1'b1, 8'd1,  2'd2, 2'd1, 32'h0000_CAFE, 8'd1,   32'h0000_12EF, 4'd2},  // R2
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd4,   32'h0000_0000, 4'd5},  // R5
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd5,   32'h0000_0001, 4'd5},  // R5
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd6,   32'h0000_000C, 4'd5},  // R5
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd9,   32'h0000_0008, 4'd5},  // R5
    '{1'b1, 8'd4,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd4,   32'hFFFF_F000, 4'd6},  // R6
    '{1'b1, 8'd4,  2'd0, 2'd2, 32'hE000_1234, 8'd4,   32'hE000_1230, 4'd5},  // R5
    '{1'b1, 8'd5,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd5,   32'hFFFF_FF01, 4'd6},  // R6
    '{1'b1, 8'd9,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd9,   32'hFFF0_0008, 4'd6},  // R6
    '{1'b1, 8'd6,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd6,   32'h0000_000C, 4'd7},  // R7
    '{1'b1, 8'd7,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd7,   32'hFFFF_FFFE, 4'd7},  // R7
    '{1'b1, 8'd7,  2'd0, 2'd2, 32'h1234_5678, 8'd7,   32'h1234_5678, 4'd7},  // R7
    '{1'b1, 8'd6,  2'd0, 2'd2, 32'hA000_0000, 8'd6,   32'hA000_000C, 4'd7},  // R7
    '{1'b1, 8'd8,  2'd0, 2'd2, 32'hFFFF_FFFF, 8'd8,   32'h0000_0000, 4'd11}, // R11
    '{1'b1, 8'd13, 2'd0, 2'd2, 32'hFFFF_FFFF, 8'd13,  32'h0000_0000, 4'd11}, // R11
    '{1'b1, 8'd12, 2'd0, 2'd2, 32'hFFFF_F801, 8'd12,  32'hFFFF_0000, 4'd8},  // R8
    '{1'b1, 8'd12, 2'd0, 2'd2, 32'hC000_0801, 8'd12,  32'hC000_0800, 4'd8},  // R8
    '{1'b1, 8'd12, 2'd0, 2'd2, 32'hFFFF_F000, 8'd12,  32'hFFFF_F000, 4'd8},  // R8
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd64,  32'hFFFF_FFFF, 4'd9},  // R9
    '{1'b0, 8'd0,  2'd0, 2'd3, 32'h0,         8'd255, 32'hFFFF_FFFF, 4'd9},  // R9
    '{1'b1, 8'd70, 2'd0, 2'd2, 32'h5000_0000, 8'd6,   32'hA000_000C, 4'd9},  // R9
    '{1'b1, 8'd3,  2'd2, 2'd1, 32'h7777,      8'd3,   32'h0000_0040, 4'd3}   // R3
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [1:0] off,
                          input logic [1:0] size, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_off = off; wr_size = size; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_size = 2'd3;
  endtask

  task automatic do_read(input logic [7:0] idx, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      if (STEPS[s].wr) do_write(STEPS[s].widx, STEPS[s].off, STEPS[s].size, STEPS[s].data);
      do_read(STEPS[s].ridx, v);
      check(int'(STEPS[s].req), v, STEPS[s].exp);
    end

    // R6: four byte writes of 0xFF do not probe
    for (int b = 0; b < 4; b++) do_write(8'd4, 2'(b), 2'd0, 32'hFF);
    do_read(8'd4, v);
    check(6, v, 32'hFFFF_FFF0);

    // R10: registered read idle, then registered vs combinational timing
    @(negedge clk);
    check(10, {31'h0, rd_valid}, 32'h0);
    rd_en = 1'b1; rd_idx = 8'd2;
    #1;
    check(10, {31'h0, rd_valid1}, 32'h1);
    check(10, rd_data1, 32'h0401_0005);
    check(10, {31'h0, rd_valid}, 32'h0);
    @(negedge clk);
    rd_en = 1'b0;
    check(10, {31'h0, rd_valid}, 32'h1);
    check(10, rd_data, 32'h0401_0005);

    // R11: reset restores initial values
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read(8'd1, v);
    check(11, v, 32'h0);
    do_read(8'd4, v);
    check(11, v, 32'h0);
    do_read(8'd12, v);
    check(11, v, 32'h0);
    do_read(8'd15, v);
    check(11, v, 32'h0000_0100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule